// File: doc/BRIEF.md
# Multichip Sync Clock-Phase Aligner

This block lines up the divided-clock phase of several converter devices that share one fast sample clock. Each device runs a 32-state phase counter at the sample-clock rate. The divided clock enables come from that counter. An external sync line, sampled in the same clock domain, produces a single-cycle initialization strobe. The strobe reloads the counter with a programmable 4-bit offset. Raising the offset by one moves every divided clock one sample-clock period earlier relative to the sync event.

Two trigger sources are available. In edge mode, every low-to-high transition of the sync line fires the strobe. In code mode, the sync line carries a serial pseudorandom sequence. The strobe fires only when the last 127 received bits equal the expected sequence. A global enable gates both sources. When strobes arrive a multiple of 32 cycles apart, each reload writes the value the counter was about to take anyway, so the running phase is not disturbed. A flag records whether the most recent strobe found the counter out of phase.

Top module: `mcs_phase_aligner`

## Requirements
- R1: `init_pulse` is never high for two consecutive clock cycles.
- R2: In edge mode (`mode_code`=0, `enable`=1), each 0-to-1 transition of `sync_in` produces exactly one `init_pulse`. If `sync_in` is first seen high at clock edge E, `init_pulse` is high in the cycle that follows edge E+2.
- R3: In code mode (`mode_code`=1), `sync_in` supplies one bit per clock. The expected sequence comes from a 7-bit register seeded with all ones. Each bit sent is the register's bit 6, after which the register shifts left and takes bit6 XOR bit5 into bit 0; the sequence is 127 bits long. If the final bit is first seen at edge E, `init_pulse` is high in the cycle after edge E+3. An incomplete or corrupted sequence produces no pulse.
- R4: Without a strobe, `clk_state` increases by one on every clock, modulo 32.
- R5: On the clock edge that ends a strobe cycle, `clk_state` takes `phase_offset`, zero-extended to 5 bits.
- R6: `div_en[i]` is high exactly when bits i down to 0 of `clk_state` are all ones, so bit i marks one cycle in every 2^(i+1).
- R7: At each strobe, `phase_err` is set to 1 if (`clk_state`+1) mod 32 differs from the offset, and to 0 otherwise. It holds its value between strobes. A second strobe 32 cycles after the first leaves the counter sequence unbroken and reports 0.
- R8: While `enable` is low, no strobe is produced from either source, and the counter keeps free-running.
- R9: In code mode, a plain rising edge on `sync_in` produces no strobe.
- R10: During reset (`rst_n` low), `clk_state`, `div_en`, `init_pulse` and `phase_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Gates all strobe generation |
| mode_code | input | 1 | 0 = edge trigger, 1 = sequence trigger |
| phase_offset | input | 4 | Counter reload value |
| sync_in | input | 1 | External sync line (asynchronous) |
| init_pulse | output | 1 | One-cycle initialization strobe |
| clk_state | output | 5 | Phase counter value |
| div_en | output | 5 | Divided clock enables, /2 to /32 |
| phase_err | output | 1 | Last strobe found the counter out of phase |

## Verification
The hardest case to reach from the ports is a correlator match. It needs 127 consecutive correct bits, so the bench builds the sequence arithmetically and feeds it one bit per clock. It also sends a copy with one bit flipped, and that copy must not fire. The aligned re-sync is just as narrow. For every offset, the bench issues a second sync edge exactly 32 cycles after the first and checks that the counter reads offset+31 just before the reload and that the error flag stays low. A 33-cycle spacing must raise the error flag.

// File: rtl/mcs_pkg.sv
// Package: shared sizes, trigger-mode type and the reference sequence
// builder used by the code-mode correlator.
// Assumes: the sequence generator polynomial is fixed at x^7 + x^6 + 1.
package mcs_pkg;

    localparam int STATE_W = 5;
    localparam int OFFS_W  = 4;
    localparam int PN_W    = 7;
    localparam int PN_LEN  = (1 << PN_W) - 1;

    typedef enum logic {
        MODE_EDGE = 1'b0,
        MODE_CODE = 1'b1
    } sync_mode_e;

    // Build the expected window: the first bit sent lands in the MSB.
    function automatic logic [PN_LEN-1:0] pn_reference();
        logic [PN_W-1:0]   gen;
        logic [PN_LEN-1:0] win;
        gen = '1;
        win = '0;
        for (int k = 0; k < PN_LEN; k++) begin
            win[PN_LEN-1-k] = gen[PN_W-1];
            gen = {gen[PN_W-2:0], gen[PN_W-1] ^ gen[PN_W-2]};
        end
        return win;
    endfunction

endpackage

// File: rtl/mcs_sync_edge.sv
// Module: multi-flop synchronizer plus a rising-edge detector.
// Assumes: STAGES >= 2. The input is asynchronous to clk, and each
// level is held for at least one clock.
module mcs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Move the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    // Keep the last synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign dout = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/mcs_code_det.sv
// Module: serial correlator that reports a full-window match against the
// reference sequence.
// Assumes: one code bit per clock while shift_en is high; newest bit in LSB.
module mcs_code_det
    import mcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic bit_in,
    output logic match
);

    localparam logic [PN_LEN-1:0] REF_WIN = pn_reference();

    logic [PN_LEN-1:0] window;

    // Shift received code bits in while the sequence trigger is selected.
    always_ff @(posedge clk) begin
        if (!rst_n)        window <= '0;
        else if (shift_en) window <= {window[PN_LEN-2:0], bit_in};
    end

    // Compare the whole window against the reference.
    always_comb begin
        match = shift_en && (window == REF_WIN);
    end

endmodule

// File: rtl/mcs_clk_fsm.sv
// Module: phase counter with a reload input, divided clock enables and an
// out-of-phase flag.
// Assumes: OFFS_W < STATE_W; the reload value is zero-extended.
module mcs_clk_fsm #(
    parameter int STATE_W = 5,
    parameter int OFFS_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [OFFS_W-1:0]  offset,
    output logic [STATE_W-1:0] state,
    output logic [STATE_W-1:0] div_en,
    output logic               phase_err
);

    logic [STATE_W-1:0] next_free;
    logic [STATE_W-1:0] reload;

    // Work out the free-running successor and the reload target.
    always_comb begin
        next_free = state + STATE_W'(1);
        reload    = {{(STATE_W-OFFS_W){1'b0}}, offset};
    end

    // Advance the counter, or jump to the reload value on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= '0;
        else if (load) state <= reload;
        else           state <= next_free;
    end

    // Record whether the latest strobe changed the counter's course.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_err <= 1'b0;
        else if (load) phase_err <= (next_free != reload);
    end

    // One enable per power-of-two divide ratio.
    for (genvar i = 0; i < STATE_W; i++) begin : g_div
        assign div_en[i] = &state[i:0];
    end

endmodule

// File: rtl/mcs_phase_aligner.sv
// Module: top of the multichip phase aligner. It selects the edge or
// sequence trigger, registers the one-cycle strobe and drives the
// phase counter.
// Assumes: sync_in is asynchronous; all other inputs are synchronous to clk.
module mcs_phase_aligner
    import mcs_pkg::*;
#(
    parameter int STATE_W     = mcs_pkg::STATE_W,
    parameter int OFFS_W      = mcs_pkg::OFFS_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               mode_code,
    input  logic [OFFS_W-1:0]  phase_offset,
    input  logic               sync_in,
    output logic               init_pulse,
    output logic [STATE_W-1:0] clk_state,
    output logic [STATE_W-1:0] div_en,
    output logic               phase_err
);

    sync_mode_e mode;
    logic       sync_s;
    logic       sync_rise;
    logic       code_hit;
    logic       fire;
    logic       init_q;

    assign mode = sync_mode_e'(mode_code);

    mcs_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_in),
        .dout  (sync_s),
        .rise  (sync_rise)
    );

    mcs_code_det i_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (mode == MODE_CODE),
        .bit_in   (sync_s),
        .match    (code_hit)
    );

    // Pick the trigger source for the current mode, gated by enable.
    always_comb begin
        fire = enable && ((mode == MODE_CODE) ? code_hit : sync_rise);
    end

    // Register the strobe so that it lasts exactly one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) init_q <= 1'b0;
        else        init_q <= fire;
    end

    mcs_clk_fsm #(.STATE_W(STATE_W), .OFFS_W(OFFS_W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (init_q),
        .offset    (phase_offset),
        .state     (clk_state),
        .div_en    (div_en),
        .phase_err (phase_err)
    );

    assign init_pulse = init_q;

endmodule

// File: rtl/mcs_phase_checker.sv
// Module: temporal checks on the aligner's ports, attached with bind.
// Assumes: synchronous active-low reset on clk.
module mcs_phase_checker #(
    parameter int STATE_W = 5,
    parameter int OFFS_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic [OFFS_W-1:0]  phase_offset,
    input logic               init_pulse,
    input logic [STATE_W-1:0] clk_state,
    input logic               phase_err
);

    // R1: the strobe is a single cycle wide
    a_r1_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);

    // R4: the counter steps by one when no strobe is present
    a_r4_free_run: assert property (@(posedge clk) disable iff (!rst_n)
        !init_pulse |=> clk_state == STATE_W'($past(clk_state) + STATE_W'(1)));

    // R5: a strobe loads the zero-extended offset
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> clk_state == {{(STATE_W-OFFS_W){1'b0}}, $past(phase_offset)});

    // R7: the error flag only changes at a strobe
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !init_pulse |=> $stable(phase_err));

    // R8: no strobe follows a cycle with enable low
    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !init_pulse);

endmodule

bind mcs_phase_aligner mcs_phase_checker #(.STATE_W(STATE_W), .OFFS_W(OFFS_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .phase_offset (phase_offset),
    .init_pulse   (init_pulse),
    .clk_state    (clk_state),
    .phase_err    (phase_err)
);

// File: tb/test_mcs_phase_aligner.sv
`timescale 1ns/1ps
module test_mcs_phase_aligner;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       mode_code = 1'b0;
    logic [3:0] phase_offset = '0;
    logic       sync_in = 1'b0;
    logic       init_pulse;
    logic [4:0] clk_state;
    logic [4:0] div_en;
    logic       phase_err;

    int checks = 0;
    int fails = 0;
    int npulse = 0;
    bit code_bits [127];

    always #2 clk = ~clk;

    mcs_phase_aligner i_mcs_phase_aligner (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_code(mode_code),
        .phase_offset(phase_offset), .sync_in(sync_in), .init_pulse(init_pulse),
        .clk_state(clk_state), .div_en(div_en), .phase_err(phase_err)
    );

    // Count strobes, sampled away from the active edge.
    always @(negedge clk) if (rst_n && init_pulse) npulse++;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int div_expect(input int s);
        int r = 0;
        for (int i = 0; i < 5; i++)
            if ((s % (2 << i)) == (2 << i) - 1) r |= (1 << i);
        return r;
    endfunction

    // Edge trigger with latency checks; pre < 0 or err < 0 skips that check.
    task automatic fire_edge(input int off, input int pre, input int err);
        int n0 = npulse;
        sync_in = 1'b1; tick(); sync_in = 1'b0;
        chk("R2 early", int'(init_pulse), 0);
        tick(); chk("R2 early", int'(init_pulse), 0);
        tick(); chk("R2 strobe", int'(init_pulse), 1);
        if (pre >= 0) chk("R7 continuity", int'(clk_state), pre);
        tick();
        chk("R1 width", int'(init_pulse), 0);
        chk("R5 reload", int'(clk_state), off);
        chk("R6 div", int'(div_en), div_expect(off));
        chk("R2 count", npulse - n0, 1);
        if (err >= 0) chk("R7 flag", int'(phase_err), err);
    endtask

    task automatic send_code(input int flip);
        for (int k = 0; k < 127; k++) begin
            sync_in = code_bits[k] ^ (k == flip);
            tick();
        end
        sync_in = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n0, s0;
        begin
            logic [6:0] g = 7'h7F;
            for (int k = 0; k < 127; k++) begin
                code_bits[k] = g[6];
                g = {g[5:0], g[6] ^ g[5]};
            end
        end
        sync_in = 1'b1;
        tick(); tick(); tick();
        chk("R10 state", int'(clk_state), 0);
        chk("R10 div", int'(div_en), 0);
        chk("R10 pulse", int'(init_pulse), 0);
        chk("R10 err", int'(phase_err), 0);
        sync_in = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        s0 = clk_state;
        for (int k = 1; k <= 40; k++) begin
            tick();
            chk("R4 step", int'(clk_state), (s0 + k) % 32);
            chk("R6 div", int'(div_en), div_expect((s0 + k) % 32));
        end
        enable = 1'b1;

        for (int off = 0; off < 16; off++) begin
            phase_offset = 4'(off);
            fire_edge(off, -1, -1);
            tick(); tick(); tick(); tick(); tick(); tick(); tick();
            chk("R4 run", int'(clk_state), (off + 7) % 32);
            for (int k = 0; k < 21; k++) tick();
            fire_edge(off, (off + 31) % 32, 0);
            for (int k = 0; k < 29; k++) tick();
            fire_edge(off, -1, 1);
        end

        enable = 1'b0;
        n0 = npulse; s0 = clk_state;
        sync_in = 1'b1; tick(); sync_in = 1'b0;
        for (int k = 0; k < 5; k++) tick();
        chk("R8 no strobe", npulse - n0, 0);
        chk("R8 counter", int'(clk_state), (s0 + 6) % 32);
        enable = 1'b1;

        mode_code = 1'b1;
        phase_offset = 4'd9;
        n0 = npulse;
        sync_in = 1'b1; tick(); sync_in = 1'b0;
        for (int k = 0; k < 6; k++) tick();
        chk("R9 edge ignored", npulse - n0, 0);

        send_code(60);
        for (int k = 0; k < 6; k++) tick();
        chk("R3 corrupted", npulse - n0, 0);

        send_code(-1);
        chk("R3 no early", npulse - n0, 0);
        tick();
        tick(); chk("R3 early", int'(init_pulse), 0);
        tick(); chk("R3 strobe", int'(init_pulse), 1);
        tick();
        chk("R1 width", int'(init_pulse), 0);
        chk("R5 code reload", int'(clk_state), 9);
        chk("R3 count", npulse - n0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule